// File: doc/BRIEF.md
# Bidirectional Row-Scan Token Driver

This block is the digital control core of a serial-in, parallel-out row driver for a scanned display. A chain of `STAGES` one-bit stages carries a single token. A strobe on the active cascade input loads the token into the head stage and clears every other stage. Each rising clock edge then moves the token one stage toward the tail, so exactly one row is selected at a time while a frame is being scanned.

A direction input picks the scan order and swaps the roles of the two cascade pin pairs. When it is high, pin A takes the strobe, the token runs from stage 0 upward, and pin B passes the token on. When it is low, pin B takes the strobe, the token runs from stage `STAGES-1` downward, and pin A passes it on.

Each stage drives a two-bit three-state code toward the high-voltage output stage, which lies outside this block. The token's stage drives high or low, as the polarity input selects. Every other stage is high-impedance. An output-disable input forces all codes to high-impedance. A registered copy of the tail stage appears on the output cascade pin, so that several devices can be chained.

Top module: `row_scan_driver`

## Requirements
- R1: When `rstN` is low (asynchronous), the chain is cleared. Every `rowCode` field reads 2'b00 and both cascade outputs read 0.
- R2: On a rising edge where the input cascade pin is high, the head stage is loaded with 1 and all other stages are cleared. The input pin is `cascAIn` when `scanDir`=1 and `cascBIn` when `scanDir`=0. The head is stage 0 when `scanDir`=1 and stage `STAGES-1` when `scanDir`=0. While the strobe stays high, the token stays at the head. The cascade input of the non-input side has no effect.
- R3: On a rising edge with no strobe, the token moves one stage. It moves from stage i to i+1 when `scanDir`=1 and from i to i-1 when `scanDir`=0.
- R4: At most one stage holds a token at any time. A token shifted past the tail leaves the chain empty, and every `rowCode` field then reads 2'b00.
- R5: The field `rowCode[2i+1:2i]` belongs to stage i. It is 2'b01 (drive-high) when stage i holds the token and `polSel`=1. It is 2'b10 (drive-low) when stage i holds the token and `polSel`=0. Otherwise it is 2'b00 (high-impedance). The code follows `polSel` combinationally.
- R6: While `outDis`=1, every `rowCode` field is 2'b00 whatever the chain holds. The effect is combinational, and the chain is not changed.
- R7: The output cascade pin goes high exactly `STAGES` rising edges after the injection edge and stays high for one clock. The output pin is `cascBOut` when `scanDir`=1 and `cascAOut` when `scanDir`=0. The other cascade output stays 0.
- R8: A strobe in the middle of a scan overrides the token's current position and restarts the scan at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| scanDir | input | 1 | 1: A is the input and scan runs upward; 0: B is the input and scan runs downward |
| polSel | input | 1 | Level driven by the selected row: 1 high, 0 low |
| outDis | input | 1 | 1 forces every row code to high-impedance |
| cascAIn | input | 1 | Cascade pin A, strobe input when `scanDir`=1 |
| cascBIn | input | 1 | Cascade pin B, strobe input when `scanDir`=0 |
| cascAOut | output | 1 | Cascade pin A, registered tail copy when `scanDir`=0 |
| cascBOut | output | 1 | Cascade pin B, registered tail copy when `scanDir`=1 |
| rowCode | output | 2*STAGES | Per-stage drive code: 00 off, 01 high, 10 low |

## Verification
The scan is driven from a vector table that mixes both directions, both polarities and the disable input over short, middle and full-length runs. This separates a wrong head or step direction from a wrong code or a wrong field position. Full-length runs in each direction count the edges until the cascade output rises, and check on every clock that exactly one row drives. These runs catch an off-by-one in the tail register and a lost or duplicated token. Directed cases cover a strobe on the wrong-side pin, a strobe held over several clocks and a strobe in mid-scan. They also cover live toggling of polarity and disable without a clock, and an asynchronous reset in mid-scan.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_LOW  = 2'b10
  } drive_e;

  typedef struct packed {
    logic load;        // inject token at head, clear the rest
    logic shiftUp;     // move token toward higher stage index
    logic shiftDown;   // move token toward lower stage index
    logic towardHigh;  // current scan order (1: upward)
  } scan_ctl_t;

endpackage

// File: rtl/row_scan_ctrl.sv
module row_scan_ctrl
  import row_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      scanDir,
  input  logic      cascAIn,
  input  logic      cascBIn,
  output scan_ctl_t ctl
);

  logic strobeSel;

  // Only the pin that the direction names as input can strobe.
  assign strobeSel = scanDir ? cascAIn : cascBIn;

  always_comb begin
    ctl            = '0;
    ctl.towardHigh = scanDir;
    ctl.load       = strobeSel;
    ctl.shiftUp    = !strobeSel && scanDir;
    ctl.shiftDown  = !strobeSel && !scanDir;
  end

  // R2: the pin on the output side never triggers a load
  p_side_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scanDir && !cascAIn) || (!scanDir && !cascBIn) |-> !ctl.load)
    else $error("p_side_ignored_r2");

  // R3: exactly one chain action per clock
  p_single_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({ctl.load, ctl.shiftUp, ctl.shiftDown}))
    else $error("p_single_action_r3");

endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain
  import row_scan_pkg::*;
#(
  parameter int STAGES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_ctl_t         ctl,
  output logic [STAGES-1:0] chain,
  output logic              tailQ
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chainNext;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic fromBelow, fromAbove, headBit;
    if (i == 0) begin : g_low_end
      assign fromBelow = 1'b0;
      assign headBit   = ctl.towardHigh;
    end else begin : g_low_mid
      assign fromBelow = chain[i-1];
      if (i == LAST) begin : g_head_hi
        assign headBit = !ctl.towardHigh;
      end else begin : g_head_none
        assign headBit = 1'b0;
      end
    end
    if (i == LAST) begin : g_high_end
      assign fromAbove = 1'b0;
    end else begin : g_high_mid
      assign fromAbove = chain[i+1];
    end
    assign chainNext[i] = ctl.load      ? headBit   :
                          ctl.shiftUp   ? fromBelow :
                          ctl.shiftDown ? fromAbove : chain[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      tailQ <= 1'b0;
    end else begin
      chain <= chainNext;
      tailQ <= ctl.towardHigh ? chain[LAST] : chain[0];
    end
  end

  // R4: never more than one token
  p_one_token_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chain))
    else $error("p_one_token_r4");

  // R2: load puts the token at the direction's head
  p_head_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && ctl.towardHigh |=> chain[0] && $countones(chain) == 1)
    else $error("p_head_up_r2");
  p_head_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !ctl.towardHigh |=> chain[LAST] && $countones(chain) == 1)
    else $error("p_head_down_r2");

  // R3: token steps one stage
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftUp && chain[0] |=> chain[1])
    else $error("p_step_up_r3");

  // R4: token leaving the tail empties the chain
  p_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftUp && chain[LAST] |=> chain == '0)
    else $error("p_exit_r4");

  // R7: tail copy follows one clock after the tail stage
  p_tail_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.towardHigh && chain[LAST] |=> tailQ)
    else $error("p_tail_copy_r7");

endmodule

// File: rtl/row_scan_encode.sv
module row_scan_encode
  import row_scan_pkg::*;
#(
  parameter int STAGES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STAGES-1:0]   chain,
  input  logic                polSel,
  input  logic                outDis,
  output logic [2*STAGES-1:0] rowCode
);

  drive_e activeCode;
  assign activeCode = polSel ? DRV_HIGH : DRV_LOW;

  for (genvar i = 0; i < STAGES; i++) begin : g_code
    assign rowCode[2*i +: 2] = (outDis || !chain[i]) ? DRV_OFF : activeCode;
  end

  // R6: disable forces every row off
  p_disable_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    outDis |-> rowCode == '0)
    else $error("p_disable_off_r6");

  // R5: empty chain drives nothing
  p_empty_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    chain == '0 |-> rowCode == '0)
    else $error("p_empty_off_r5");

endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
  import row_scan_pkg::*;
#(
  parameter int STAGES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanDir,
  input  logic                polSel,
  input  logic                outDis,
  input  logic                cascAIn,
  input  logic                cascBIn,
  output logic                cascAOut,
  output logic                cascBOut,
  output logic [2*STAGES-1:0] rowCode
);

  scan_ctl_t         ctl;
  logic [STAGES-1:0] chain;
  logic              tailQ;

  row_scan_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .scanDir (scanDir),
    .cascAIn (cascAIn),
    .cascBIn (cascBIn),
    .ctl     (ctl)
  );

  row_scan_chain #(.STAGES(STAGES)) u_chain (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .chain (chain),
    .tailQ (tailQ)
  );

  row_scan_encode #(.STAGES(STAGES)) u_encode (
    .clk     (clk),
    .rstN    (rstN),
    .chain   (chain),
    .polSel  (polSel),
    .outDis  (outDis),
    .rowCode (rowCode)
  );

  assign cascBOut = scanDir  && tailQ;
  assign cascAOut = !scanDir && tailQ;

  // R7: only the output-side cascade pin may be high
  p_casc_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cascAOut && cascBOut))
    else $error("p_casc_exclusive_r7");

endmodule

// File: tb/row_scan_driver_tb.sv
module row_scan_driver_tb;

  localparam int N = 64;
  localparam int W = 2 * N;
  localparam int WD_CYCLES = 100000;

  typedef struct packed {
    logic       dir;
    logic       pol;
    logic       dis;
    logic [7:0] steps;
    logic [7:0] expPos;
    logic [1:0] expCode;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 8'd0,  8'd0,  2'b01},
    '{1'b1, 1'b0, 1'b0, 8'd5,  8'd5,  2'b10},
    '{1'b1, 1'b1, 1'b1, 8'd7,  8'd7,  2'b00},
    '{1'b0, 1'b1, 1'b0, 8'd0,  8'd63, 2'b01},
    '{1'b0, 1'b0, 1'b0, 8'd20, 8'd43, 2'b10},
    '{1'b1, 1'b1, 1'b0, 8'd63, 8'd63, 2'b01},
    '{1'b0, 1'b1, 1'b0, 8'd63, 8'd0,  2'b01}
  };

  logic clk = 1'b0;
  logic rstN, scanDir, polSel, outDis, cascAIn, cascBIn;
  logic cascAOut, cascBOut;
  logic [W-1:0] rowCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  row_scan_driver #(.STAGES(N)) u_dut (
    .clk(clk), .rstN(rstN), .scanDir(scanDir), .polSel(polSel),
    .outDis(outDis), .cascAIn(cascAIn), .cascBIn(cascBIn),
    .cascAOut(cascAOut), .cascBOut(cascBOut), .rowCode(rowCode)
  );

  function automatic logic [W-1:0] expVec(input int pos, input logic [1:0] code);
    logic [W-1:0] v = '0;
    v[2*pos +: 2] = code;
    return v;
  endfunction

  function automatic int drivers(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) if (v[2*i +: 2] != 2'b00) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic dir);
    scanDir = dir;
    if (dir) cascAIn = 1'b1; else cascBIn = 1'b1;
    tick();
    cascAIn = 1'b0;
    cascBIn = 1'b0;
  endtask

  task automatic fullRun(input logic dir);
    int  first = -1;
    bit  oneDrv = 1'b1;
    bit  otherQuiet = 1'b1;
    polSel = 1'b1;
    outDis = 1'b0;
    pulse(dir);
    for (int i = 1; i <= N + 1; i++) begin
      tick();
      if ((dir ? cascBOut : cascAOut) && first < 0) first = i;
      if (dir ? cascAOut : cascBOut) otherQuiet = 1'b0;
      if (i < N && drivers(rowCode) != 1) oneDrv = 1'b0;
    end
    check(first == N, "R7 cascade edge count", W'(first), W'(N));
    check(otherQuiet, "R7 input-side cascade stays 0", W'(otherQuiet), W'(1));
    check(oneDrv, "R4 one driver per clock", W'(oneDrv), W'(1));
    check(rowCode == '0, "R4 chain empty after exit", rowCode, '0);
    check((dir ? cascBOut : cascAOut) == 1'b0, "R7 cascade one clock wide",
          W'(dir ? cascBOut : cascAOut), '0);
  endtask

  initial begin
    #(WD_CYCLES * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; scanDir = 1'b1; polSel = 1'b1; outDis = 1'b0;
    cascAIn = 1'b0; cascBIn = 1'b0;
    tick(); tick();
    // R1 reset state
    check(rowCode == '0, "R1 reset rowCode", rowCode, '0);
    check({cascAOut, cascBOut} == 2'b00, "R1 reset cascade", W'({cascAOut, cascBOut}), '0);
    rstN = 1'b1;
    tick();

    // table walk: R3 step, R5 code, R6 disable
    foreach (VECS[k]) begin
      polSel = VECS[k].pol;
      outDis = VECS[k].dis;
      pulse(VECS[k].dir);
      repeat (int'(VECS[k].steps)) tick();
      check(rowCode == expVec(int'(VECS[k].expPos), VECS[k].expCode),
            VECS[k].dis ? "R6 table" : "R3 R5 table",
            rowCode, expVec(int'(VECS[k].expPos), VECS[k].expCode));
    end
    outDis = 1'b0;
    polSel = 1'b1;

    // full runs both directions: R7, R4
    fullRun(1'b1);
    fullRun(1'b0);

    // R2: wrong-side pin ignored
    pulse(1'b1);
    repeat (3) tick();
    cascBIn = 1'b1;
    tick();
    cascBIn = 1'b0;
    check(rowCode == expVec(4, 2'b01), "R2 other pin ignored", rowCode, expVec(4, 2'b01));

    // R2: held strobe keeps token at head
    cascAIn = 1'b1;
    repeat (3) tick();
    check(rowCode == expVec(0, 2'b01), "R2 held strobe", rowCode, expVec(0, 2'b01));
    cascAIn = 1'b0;
    repeat (2) tick();
    check(rowCode == expVec(2, 2'b01), "R2 release then step", rowCode, expVec(2, 2'b01));

    // R8: mid-scan override, downward
    pulse(1'b0);
    repeat (10) tick();
    check(rowCode == expVec(53, 2'b01), "R3 downward step", rowCode, expVec(53, 2'b01));
    pulse(1'b0);
    check(rowCode == expVec(63, 2'b01), "R8 override", rowCode, expVec(63, 2'b01));

    // R5/R6 live, no clock edge
    outDis = 1'b1; #1;
    check(rowCode == '0, "R6 live disable", rowCode, '0);
    outDis = 1'b0; #1;
    check(rowCode == expVec(63, 2'b01), "R6 chain kept", rowCode, expVec(63, 2'b01));
    polSel = 1'b0; #1;
    check(rowCode == expVec(63, 2'b10), "R5 live polarity", rowCode, expVec(63, 2'b10));

    // R1 asynchronous reset mid-scan
    rstN = 1'b0; #1;
    check(rowCode == '0, "R1 async reset", rowCode, '0);
    tick();
    rstN = 1'b1;
    tick();
    check(rowCode == '0, "R1 stays empty", rowCode, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule